// File: doc/BRIEF.md
# Programmable-Polynomial Bit-Serial GF(2^m) Multiplier

This block multiplies two elements of a binary extension field GF(2^m) in polynomial basis, one bit of the second operand per clock, least significant bit first. The field polynomial is F(x) = x^m + G(x), and the low part G(x) sits in a loadable coefficient register instead of fixed wiring. Software loads G once, then issues any number of multiplications against it. The datapath is 163 bits wide and handles every field size from 1 to 163.

On every iteration the multiplicand register is multiplied by x. When the bit leaving the top position is 1, the stored coefficients are folded back in by XOR. The current lowest bit of the multiplier operand decides whether the multiplicand is XORed into the accumulator. A field of size m < 163 runs on the same datapath. The caller places A and G in the upper bits (shifted left by 163 − m), places B in the lower bits, and sets the iteration count to m. After m iterations the product sits in the upper m bits of the result.

Top module: `gfm_serial_mult`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0, `c_out` is 0 and the coefficient register holds 0.
- R2: A `g_load` pulse while `busy` is 0 stores `g_in` as the coefficients G, bit i being the coefficient of x^i. The stored value is used by every later multiplication.
- R3: With `len_in` = 163, `c_out` equals A·B mod (x^163 + G) when the run completes.
- R4: A `start` accepted while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, L rising edges after the accepting edge, where L is the effective length. `busy` falls together with the rise of `done`.
- R5: For m < 163 with `len_in` = m, A and G shifted left by 163 − m and B right-aligned, `c_out` equals (A'·B' mod F'(x)) shifted left by 163 − m. Its lower 163 − m bits are 0.
- R6: A `len_in` of 0 is treated as 1, and a value above 163 is treated as 163.
- R7: A `g_load` while `busy` is 1 is ignored. Neither the running multiplication nor any later one sees the offered value.
- R8: A `start` while `busy` is 1 is ignored. The running multiplication keeps its operands and its completion time.
- R9: An accepted `start` clears the accumulator. After completion, `c_out` holds the result until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| g_load | input | 1 | Store `g_in` as the reduction coefficients (idle only) |
| g_in | input | 163 | Reduction coefficients G, bit i is x^i |
| start | input | 1 | Begin a multiplication (idle only) |
| a_in | input | 163 | Multiplicand A |
| b_in | input | 163 | Multiplier B, consumed LSB first |
| len_in | input | 8 | Iteration count m, 1..163 (clamped) |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle completion pulse |
| c_out | output | 163 | Accumulated product |

## Verification
The checker watches, on every cycle, the handshake timing: the single-cycle `done` pulse, `busy` falling with it, and `busy` rising after an accepted start. It also checks that the coefficient register stays frozen while busy and takes `g_in` on an idle load, that the accumulator is cleared on acceptance, and that the result holds while idle. Arithmetic correctness cannot be checked as a property. The bench scenarios cover it by comparing against a schoolbook multiply-then-divide model: the 163-bit pentanomial field, the 113-bit aligned field and the one-bit field. Only those scenarios can show the exact iteration count, the length clamping, and that operands offered mid-run are ignored.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    localparam int unsigned FIELD_MAX = 163;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic accept;
        logic step;
        logic last;
    } seq_ctl_t;

    function automatic int unsigned len_bits(input int unsigned w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/gfm_seq.sv
module gfm_seq
    import gfm_pkg::*;
#(
    parameter int unsigned W  = FIELD_MAX,
    parameter int unsigned LW = len_bits(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [LW-1:0] len_in,
    output seq_ctl_t      ctl,
    output logic          busy,
    output logic          done
);

    localparam logic [LW-1:0] LEN_MAX = LW'(W);
    localparam logic [LW-1:0] LEN_ONE = LW'(1);

    phase_e        phase_q;
    logic [LW-1:0] cnt_q;
    logic [LW-1:0] len_eff;
    logic          done_q;

    // Clamp requested length into 1..W
    always_comb begin
        if (len_in == '0) begin
            len_eff = LEN_ONE;
        end else if (len_in > LEN_MAX) begin
            len_eff = LEN_MAX;
        end else begin
            len_eff = len_in;
        end
    end

    always_comb begin
        ctl.accept = start && (phase_q == PH_IDLE);
        ctl.step   = (phase_q == PH_RUN);
        ctl.last   = (phase_q == PH_RUN) && (cnt_q == LEN_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= ctl.last;
            if (ctl.accept) begin
                phase_q <= PH_RUN;
                cnt_q   <= len_eff;
            end else if (ctl.step) begin
                cnt_q <= cnt_q - LEN_ONE;
                if (ctl.last) begin
                    phase_q <= PH_IDLE;
                end
            end
        end
    end

    assign busy = (phase_q == PH_RUN);
    assign done = done_q;

endmodule

// File: rtl/gfm_poly_reg.sv
module gfm_poly_reg
    import gfm_pkg::*;
#(
    parameter int unsigned W = FIELD_MAX
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic         busy,
    input  logic [W-1:0] g_in,
    output logic [W-1:0] g_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= '0;
        end else if (we && !busy) begin
            g_q <= g_in;
        end
    end

endmodule

// File: rtl/gfm_areg.sv
module gfm_areg
    import gfm_pkg::*;
#(
    parameter int unsigned W = FIELD_MAX
) (
    input  logic         clk,
    input  logic         rst,
    input  seq_ctl_t     ctl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] g,
    output logic [W-1:0] a_q
);

    logic [W-1:0] a_next;
    logic         carry;

    assign carry = a_q[W-1];

    // a_next = a * x mod (x^W + g), one tap per bit
    assign a_next[0] = carry & g[0];
    for (genvar i = 1; i < W; i++) begin : g_tap
        assign a_next[i] = a_q[i-1] ^ (carry & g[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else if (ctl.accept) begin
            a_q <= a_in;
        end else if (ctl.step) begin
            a_q <= a_next;
        end
    end

endmodule

// File: rtl/gfm_accum.sv
module gfm_accum
    import gfm_pkg::*;
#(
    parameter int unsigned W = FIELD_MAX
) (
    input  logic         clk,
    input  logic         rst,
    input  seq_ctl_t     ctl,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] a_cur,
    output logic [W-1:0] c_q
);

    logic [W-1:0] b_q;
    logic [W-1:0] gated;

    assign gated = b_q[0] ? a_cur : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
            c_q <= '0;
        end else if (ctl.accept) begin
            b_q <= b_in;
            c_q <= '0;
        end else if (ctl.step) begin
            b_q <= b_q >> 1;
            c_q <= c_q ^ gated;
        end
    end

endmodule

// File: rtl/gfm_serial_mult.sv
module gfm_serial_mult
    import gfm_pkg::*;
#(
    parameter int unsigned W  = FIELD_MAX,
    parameter int unsigned LW = len_bits(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          g_load,
    input  logic [W-1:0]  g_in,
    input  logic          start,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    input  logic [LW-1:0] len_in,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  c_out
);

    seq_ctl_t     ctl;
    logic [W-1:0] poly_q;
    logic [W-1:0] a_cur;

    gfm_seq #(.W(W), .LW(LW)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .len_in (len_in),
        .ctl    (ctl),
        .busy   (busy),
        .done   (done)
    );

    gfm_poly_reg #(.W(W)) u_poly (
        .clk  (clk),
        .rst  (rst),
        .we   (g_load),
        .busy (busy),
        .g_in (g_in),
        .g_q  (poly_q)
    );

    gfm_areg #(.W(W)) u_areg (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .a_in (a_in),
        .g    (poly_q),
        .a_q  (a_cur)
    );

    gfm_accum #(.W(W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .b_in  (b_in),
        .a_cur (a_cur),
        .c_q   (c_out)
    );

endmodule

// File: rtl/gfm_chk.sv
module gfm_chk #(
    parameter int unsigned W = 163
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         g_load,
    input logic [W-1:0] g_in,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] c_out,
    input logic [W-1:0] g_q
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R4

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R4

    AST_POLY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(g_q)); // R7

    AST_POLY_LOAD: assert property (@(posedge clk) disable iff (rst)
        (g_load && !busy) |=> (g_q == $past(g_in))); // R2

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (c_out == '0)); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(c_out)); // R9

endmodule

bind gfm_serial_mult gfm_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .g_load (g_load),
    .g_in   (g_in),
    .busy   (busy),
    .done   (done),
    .c_out  (c_out),
    .g_q    (poly_q)
);

// File: tb/tb_gfm_serial_mult.sv
module tb_gfm_serial_mult;

    localparam int W  = 163;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          g_load = 1'b0;
    logic [W-1:0]  g_in = '0;
    logic          start = 1'b0;
    logic [W-1:0]  a_in = '0;
    logic [W-1:0]  b_in = '0;
    logic [LW-1:0] len_in = '0;
    logic          busy;
    logic          done;
    logic [W-1:0]  c_out;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] NIST = (ONE << 7) | (ONE << 6) | (ONE << 3) | ONE;

    always #4 clk = ~clk;

    gfm_serial_mult dut (
        .clk(clk), .rst(rst), .g_load(g_load), .g_in(g_in), .start(start),
        .a_in(a_in), .b_in(b_in), .len_in(len_in), .busy(busy), .done(done),
        .c_out(c_out)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Schoolbook product followed by long division by x^m + g
    function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [W-1:0] g, input int m);
        logic [2*W-1:0] p;
        p = '0;
        for (int i = 0; i < m; i++)
            if (b[i]) p = p ^ ({{W{1'b0}}, a} << i);
        for (int i = 2*m - 2; i >= m; i--)
            if (p[i]) begin
                p[i] = 1'b0;
                p = p ^ ({{W{1'b0}}, g} << (i - m));
            end
        return p[W-1:0];
    endfunction

    function automatic logic [W-1:0] rnd(input int m);
        logic [191:0] v;
        v = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        return v[W-1:0] & ({W{1'b1}} >> (W - m));
    endfunction

    task automatic load_g(input logic [W-1:0] g);
        @(negedge clk); g_in = g; g_load = 1'b1;
        @(posedge clk);
        @(negedge clk); g_load = 1'b0;
    endtask

    task automatic wait_done(inout int cyc);
        while (cyc < 400) begin
            @(posedge clk); cyc++;
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic do_mul(input logic [W-1:0] a, input logic [W-1:0] b, input int len,
                          output logic [W-1:0] res, output int cyc);
        @(negedge clk); a_in = a; b_in = b; len_in = LW'(len); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        cyc = 0;
        wait_done(cyc);
        res = c_out;
    endtask

    task automatic t_reset;
        check("R1 busy", W'(busy), '0);
        check("R1 done", W'(done), '0);
        check("R1 c_out", c_out, '0);
        // zero coefficients: x^162 * x reduces to 0
        begin
            logic [W-1:0] r; int c;
            do_mul(ONE << 162, ONE << 1, 163, r, c);
            check("R1 G cleared", r, '0);
        end
    endtask

    task automatic t_full163;
        logic [W-1:0] r, a, b; int c;
        load_g(NIST); // R2
        do_mul(ONE, ONE, 163, r, c);
        check("R3 1*1", r, ONE);
        check("R4 latency 163", W'(c), W'(163));
        do_mul(ONE << 162, ONE << 1, 163, r, c);
        check("R2 R3 x^163 folds to G", r, NIST);
        for (int k = 0; k < 4; k++) begin
            a = rnd(163); b = rnd(163);
            do_mul(a, b, 163, r, c);
            check("R3 random 163", r, ref_mul(a, b, NIST, 163));
        end
    endtask

    task automatic t_align113;
        logic [W-1:0] g, r, a, b; int c;
        g = (ONE << 9) | ONE;
        load_g(g << 50);
        for (int k = 0; k < 3; k++) begin
            a = rnd(113); b = rnd(113);
            do_mul(a << 50, b, 113, r, c);
            check("R5 113 aligned", r, ref_mul(a, b, g, 113) << 50);
            check("R4 latency 113", W'(c), W'(113));
        end
    endtask

    task automatic t_clamp;
        logic [W-1:0] r; int c;
        load_g(ONE << 162);
        do_mul(ONE << 162, ONE, 0, r, c);
        check("R6 len0 result", r, ONE << 162);
        check("R6 len0 cycles", W'(c), W'(1));
        load_g(NIST);
        do_mul(ONE << 162, ONE << 1, 200, r, c);
        check("R6 len200 result", r, NIST);
        check("R6 len200 cycles", W'(c), W'(163));
    endtask

    task automatic t_gload_busy;
        logic [W-1:0] r; int c;
        load_g(NIST);
        @(negedge clk); a_in = ONE << 162; b_in = ONE << 1; len_in = LW'(163); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        c = 0;
        repeat (20) begin @(posedge clk); c++; end
        @(negedge clk); g_in = {W{1'b1}}; g_load = 1'b1;
        @(posedge clk); c++;
        @(negedge clk); g_load = 1'b0;
        wait_done(c);
        check("R7 run keeps G", c_out, NIST);
        do_mul(ONE << 162, ONE << 1, 163, r, c);
        check("R7 later run keeps G", r, NIST);
    endtask

    task automatic t_start_busy;
        logic [W-1:0] a1, b1; int c;
        a1 = rnd(163); b1 = rnd(163);
        @(negedge clk); a_in = a1; b_in = b1; len_in = LW'(163); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        c = 0;
        repeat (30) begin @(posedge clk); c++; end
        @(negedge clk);
        check("R4 busy mid-run", W'(busy), W'(1));
        a_in = rnd(163); b_in = rnd(163); len_in = LW'(5); start = 1'b1;
        @(posedge clk); c++;
        @(negedge clk); start = 1'b0;
        wait_done(c);
        check("R8 completion time", W'(c), W'(163));
        check("R8 operands kept", c_out, ref_mul(a1, b1, NIST, 163));
    endtask

    task automatic t_hold;
        logic [W-1:0] r; int c;
        do_mul(ONE << 100, ONE << 5, 163, r, c);
        repeat (6) @(negedge clk);
        check("R9 result held", c_out, r);
        check("R4 done single", W'(done), '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R4 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_full163();
        t_align113();
        t_clamp();
        t_gload_busy();
        t_start_busy();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule